// File: doc/BRIEF.md
# Message Object Interrupt and Status Unit

This block holds the per-object event flags of a CAN controller's message memory: new data, interrupt pending, message lost and transmit request for each of `N` message objects. Next to them it keeps the controller status word, the error counter word and the interrupt identifier. Bit decoding on the wire is not modelled. A neighbouring protocol engine reports a finished reception as a one-cycle event carrying the identifier, and a finished transmission as a one-cycle event carrying the object index. It also reports every bus event, with its error code, and its current error counters.

A received frame goes into the lowest-numbered valid receive object whose new-data flag is clear. The search stops at the first valid receive object marked end-of-buffer, so a run of receive objects acts as a hardware FIFO. When every object in that run still holds unread data, the frame overwrites the end object and sets that object's message-lost flag. Software acknowledges objects through a small command port. It reads and clears status through strobes. It takes the interrupt identifier and the interrupt line as its entry point for service.

Objects are indexed from 0 on every port and vector. Index `i` is message object `i+1`, so vector bit `n-1` belongs to object `n`.

Top module: `msg_obj_irq_unit`

## Requirements
- R1: During and right after reset, every per-object flag is clear, `int_id` is 0, `irq` is 0, `err_cnt` is 0 and `status` reads 8'h07 (error-code field 7 means no update yet).
- R2: `int_id` reads 16'h8000 while a status interrupt is pending. Otherwise it reads i+1 for the lowest index i whose interrupt-pending bit is set, or 0 when none is set.
- R3: On `rx_evt` the frame is stored in the lowest valid receive object (cfg_bits[0]=1, cfg_bits[1]=0) with new data clear, at or below the chain end. The chain end is the first valid receive object with cfg_bits[2]=1, or the highest valid receive object if none has it set. Storing sets that object's new-data and interrupt-pending bits and records `rx_id`. With no valid receive object, `rx_evt` changes nothing.
- R4: When every valid receive object up to the chain end has new data set, the frame overwrites the chain-end object, records `rx_id` there and sets its message-lost bit.
- R5: `tx_done` for an object whose transmit request is set clears that request, sets the status TX OK bit and, if the object's cfg_bits[3] (transmit interrupt enable) is set, sets its interrupt-pending bit. `tx_done` for an object without a request has no effect.
- R6: `status[7]` (bus-off) follows `bus_off`. `status[6]` (warning) is tec>=96 or rec>=96. `status[5]` (passive) is tec>=128 or `rec_passive`. Each of these is registered one cycle. `err_cnt` is {rec_passive, rec[6:0], tec[7:0]}, also registered. `status[4]` (RX OK) and `status[3]` (TX OK) are set by a store or a completion and keep their value until `sts_we` writes `sts_wdata[4]`/`sts_wdata[3]`.
- R7: `status[2:0]` takes `bus_lec` on `bus_evt` and `sts_wdata[2:0]` on `sts_we`. The bus event wins when both occur in one cycle.
- R8: A status interrupt becomes pending when any of status[7:5] changes while ctrl[3] is set, or when a store or completion occurs while ctrl[2] is set. `sts_rd` clears it, and a new cause in the same cycle wins over the clear.
- R9: `irq` is high exactly when ctrl[1] is set and `int_id` is non-zero.
- R10: `ack_we` clears, for object `obj_sel`, new data if ack_mask[0], interrupt pending if ack_mask[1] and message lost if ack_mask[2]. `cfg_we` loads cfg_bits and clears all four flags of `obj_sel`. `txreq_we` sets its transmit request. Within one cycle the order is configure, then acknowledge, then request, then completion, then store, and the later action wins.
- R11: `rd_id` shows the identifier last stored in object `rd_obj` (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 4 | Enables: [1] interrupt line, [2] status-change causes, [3] error-state causes |
| cfg_we | input | 1 | Configure object `obj_sel` |
| obj_sel | input | IW | Object index for configure, acknowledge and request |
| cfg_bits | input | 4 | [0] valid, [1] transmit, [2] end of buffer, [3] transmit interrupt enable |
| ack_we | input | 1 | Acknowledge object `obj_sel` |
| ack_mask | input | 3 | [0] new data, [1] pending, [2] lost: flags to clear |
| txreq_we | input | 1 | Set transmit request of `obj_sel` |
| rx_evt | input | 1 | Frame received |
| rx_id | input | IDW | Identifier of the received frame |
| tx_done | input | 1 | Transmission finished |
| tx_obj | input | IW | Object whose transmission finished |
| bus_evt | input | 1 | Bus event with error code |
| bus_lec | input | 3 | Error code: 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 unused |
| tec | input | 8 | Transmit error count |
| rec | input | 7 | Receive error count |
| rec_passive | input | 1 | Receiver error-passive flag |
| bus_off | input | 1 | Bus-off state |
| sts_we | input | 1 | Write RX OK, TX OK and the error-code field |
| sts_wdata | input | 5 | [4] RX OK, [3] TX OK, [2:0] error code |
| sts_rd | input | 1 | Status read strobe, clears the status interrupt |
| rd_obj | input | IW | Object index for `rd_id` |
| int_id | output | 16 | Interrupt identifier |
| irq | output | 1 | Interrupt line |
| status | output | 8 | Status word |
| err_cnt | output | 16 | Error counter word |
| intpnd_vec | output | N | Interrupt-pending bits |
| newdat_vec | output | N | New-data bits |
| msglst_vec | output | N | Message-lost bits |
| txrqst_vec | output | N | Transmit-request bits |
| rd_id | output | IDW | Stored identifier of `rd_obj` |

## Verification
The bench goes after the FIFO edge cases. One frame arrives after an acknowledge frees a low object, which must refill that low object and not append after the last filled one. Another arrives when the chain is full, which must overwrite only the end-of-buffer object and flag the loss, not drop the frame or spill into transmit objects. It checks that a pending status interrupt hides object numbers until the status read, and that a state change with the error enable off raises nothing. Two further cases catch a design that completes transmissions blindly or gets the write priority backwards: a completion for an object with no request pending, and a bus event that coincides with a software write of the error-code field.

// File: rtl/msgu_pkg.sv
package msgu_pkg;
  localparam logic [15:0] STAT_CODE = 16'h8000;

  typedef enum logic [2:0] {
    LEC_NONE = 3'd0, LEC_STUFF = 3'd1, LEC_FORM = 3'd2, LEC_ACK = 3'd3,
    LEC_BIT1 = 3'd4, LEC_BIT0 = 3'd5, LEC_CRC = 3'd6, LEC_NOUPD = 3'd7
  } lec_e;

  // warning level: either counter at or above the limit
  function automatic logic warn_level(input logic [7:0] tx_cnt, input logic [6:0] rx_cnt,
                                      input int lim);
    return (int'(tx_cnt) >= lim) || (int'(rx_cnt) >= lim);
  endfunction

  // passive level: transmit counter at or above limit, or receiver flagged passive
  function automatic logic passive_level(input logic [7:0] tx_cnt, input logic rx_pass,
                                         input int lim);
    return (int'(tx_cnt) >= lim) || rx_pass;
  endfunction
endpackage

// File: rtl/msgu_rx_alloc.sv
module msgu_rx_alloc #(
  parameter int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid,
  input  logic [N-1:0]  is_tx,
  input  logic [N-1:0]  eob,
  input  logic [N-1:0]  newdat,
  output logic          hit,
  output logic          lost,
  output logic [IW-1:0] idx
);
  logic          done, free_found, any_rx;
  logic [IW-1:0] free_idx, last_idx;

  always_comb begin
    done = 1'b0; free_found = 1'b0; any_rx = 1'b0;
    free_idx = '0; last_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!done && valid[i] && !is_tx[i]) begin
        any_rx   = 1'b1;
        last_idx = IW'(i);
        if (!free_found && !newdat[i]) begin
          free_found = 1'b1;
          free_idx   = IW'(i);
        end
        if (eob[i]) done = 1'b1;
      end
    end
    hit  = any_rx;
    lost = any_rx && !free_found;
    idx  = free_found ? free_idx : last_idx;
  end
endmodule

// File: rtl/msgu_int_enc.sv
module msgu_int_enc #(
  parameter int N = 32
) (
  input  logic         stat_pend,
  input  logic [N-1:0] intpnd,
  output logic [15:0]  int_id
);
  import msgu_pkg::*;
  always_comb begin
    int_id = 16'd0;
    for (int i = N - 1; i >= 0; i--)
      if (intpnd[i]) int_id = 16'(i + 1);
    if (stat_pend) int_id = STAT_CODE;
  end
endmodule

// File: rtl/msgu_status.sv
module msgu_status #(
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  ctrl,
  input  logic [7:0]  tec,
  input  logic [6:0]  rec,
  input  logic        rec_passive,
  input  logic        bus_off,
  input  logic        bus_evt,
  input  logic [2:0]  bus_lec,
  input  logic        sts_we,
  input  logic [4:0]  sts_wdata,
  input  logic        sts_rd,
  input  logic        rx_stored,
  input  logic        tx_completed,
  output logic [7:0]  status,
  output logic [15:0] err_cnt,
  output logic        stat_pend,
  output logic        stat_set
);
  import msgu_pkg::*;
  logic [2:0] st_q, st_d;
  logic       rxok_q, txok_q;
  logic [2:0] lec_q;
  logic       st_change;

  assign st_d      = {bus_off, warn_level(tec, rec, WARN_LIM), passive_level(tec, rec_passive, PASS_LIM)};
  assign st_change = (st_d != st_q);
  assign stat_set  = (st_change && ctrl[3]) || ((rx_stored || tx_completed) && ctrl[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0; rxok_q <= 1'b0; txok_q <= 1'b0;
      lec_q <= LEC_NOUPD; err_cnt <= '0; stat_pend <= 1'b0;
    end else begin
      st_q    <= st_d;
      err_cnt <= {rec_passive, rec, tec};
      if (sts_we) begin
        rxok_q <= sts_wdata[4];
        txok_q <= sts_wdata[3];
        lec_q  <= sts_wdata[2:0];
      end
      if (rx_stored)    rxok_q <= 1'b1;
      if (tx_completed) txok_q <= 1'b1;
      if (bus_evt)      lec_q  <= bus_lec;
      if (sts_rd)   stat_pend <= 1'b0;
      if (stat_set) stat_pend <= 1'b1;
    end
  end

  assign status = {st_q, rxok_q, txok_q, lec_q};
endmodule

// File: rtl/msg_obj_irq_unit.sv
module msg_obj_irq_unit #(
  parameter int N   = 32,
  parameter int IDW = 11,
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     ctrl,
  input  logic           cfg_we,
  input  logic [IW-1:0]  obj_sel,
  input  logic [3:0]     cfg_bits,
  input  logic           ack_we,
  input  logic [2:0]     ack_mask,
  input  logic           txreq_we,
  input  logic           rx_evt,
  input  logic [IDW-1:0] rx_id,
  input  logic           tx_done,
  input  logic [IW-1:0]  tx_obj,
  input  logic           bus_evt,
  input  logic [2:0]     bus_lec,
  input  logic [7:0]     tec,
  input  logic [6:0]     rec,
  input  logic           rec_passive,
  input  logic           bus_off,
  input  logic           sts_we,
  input  logic [4:0]     sts_wdata,
  input  logic           sts_rd,
  input  logic [IW-1:0]  rd_obj,
  output logic [15:0]    int_id,
  output logic           irq,
  output logic [7:0]     status,
  output logic [15:0]    err_cnt,
  output logic [N-1:0]   intpnd_vec,
  output logic [N-1:0]   newdat_vec,
  output logic [N-1:0]   msglst_vec,
  output logic [N-1:0]   txrqst_vec,
  output logic [IDW-1:0] rd_id
);
  logic [N-1:0]   c_valid, c_tx, c_eob, c_txie;
  logic [IDW-1:0] ids [N];

  // named internal events
  logic          rx_hit, rx_lost, rx_fire, tx_fire, stat_pend, stat_set;
  logic [IW-1:0] rx_idx;

  msgu_rx_alloc #(.N(N)) u_alloc (
    .valid(c_valid), .is_tx(c_tx), .eob(c_eob), .newdat(newdat_vec),
    .hit(rx_hit), .lost(rx_lost), .idx(rx_idx)
  );

  assign rx_fire = rx_evt && rx_hit;
  assign tx_fire = tx_done && txrqst_vec[tx_obj];

  msgu_status u_status (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tec(tec), .rec(rec),
    .rec_passive(rec_passive), .bus_off(bus_off), .bus_evt(bus_evt),
    .bus_lec(bus_lec), .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rd(sts_rd),
    .rx_stored(rx_fire), .tx_completed(tx_fire), .status(status),
    .err_cnt(err_cnt), .stat_pend(stat_pend), .stat_set(stat_set)
  );

  msgu_int_enc #(.N(N)) u_enc (
    .stat_pend(stat_pend), .intpnd(intpnd_vec), .int_id(int_id)
  );

  assign irq   = ctrl[1] && (int_id != 16'd0);
  assign rd_id = ids[rd_obj];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_valid <= '0; c_tx <= '0; c_eob <= '0; c_txie <= '0;
      intpnd_vec <= '0; newdat_vec <= '0; msglst_vec <= '0; txrqst_vec <= '0;
      for (int i = 0; i < N; i++) ids[i] <= '0;
    end else begin
      if (cfg_we) begin
        c_valid[obj_sel]    <= cfg_bits[0];
        c_tx[obj_sel]       <= cfg_bits[1];
        c_eob[obj_sel]      <= cfg_bits[2];
        c_txie[obj_sel]     <= cfg_bits[3];
        newdat_vec[obj_sel] <= 1'b0;
        intpnd_vec[obj_sel] <= 1'b0;
        msglst_vec[obj_sel] <= 1'b0;
        txrqst_vec[obj_sel] <= 1'b0;
      end
      if (ack_we) begin
        if (ack_mask[0]) newdat_vec[obj_sel] <= 1'b0;
        if (ack_mask[1]) intpnd_vec[obj_sel] <= 1'b0;
        if (ack_mask[2]) msglst_vec[obj_sel] <= 1'b0;
      end
      if (txreq_we) txrqst_vec[obj_sel] <= 1'b1;
      if (tx_fire) begin
        txrqst_vec[tx_obj] <= 1'b0;
        if (c_txie[tx_obj]) intpnd_vec[tx_obj] <= 1'b1;
      end
      if (rx_fire) begin
        newdat_vec[rx_idx] <= 1'b1;
        intpnd_vec[rx_idx] <= 1'b1;
        ids[rx_idx]        <= rx_id;
        if (rx_lost) msglst_vec[rx_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/msgu_chk.sv
module msgu_chk #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ctrl,
  input logic          irq,
  input logic [15:0]   int_id,
  input logic [N-1:0]  intpnd_vec,
  input logic [N-1:0]  newdat_vec,
  input logic [N-1:0]  msglst_vec,
  input logic [N-1:0]  txrqst_vec,
  input logic [7:0]    status,
  input logic          stat_pend,
  input logic          stat_set,
  input logic          sts_rd,
  input logic          bus_evt,
  input logic [2:0]    bus_lec,
  input logic          tx_fire,
  input logic [IW-1:0] tx_obj,
  input logic          rx_fire,
  input logic          rx_lost,
  input logic [IW-1:0] rx_idx
);
  logic [IW-1:0] id_m1;
  logic [N-1:0]  below;
  always_comb begin
    id_m1 = IW'(int_id - 16'd1);
    below = (N'(1) << id_m1) - N'(1);
  end

  // R2
  stat_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_pend |-> int_id == 16'h8000);
  // R2
  lowest_obj_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_pend && int_id != 16'd0) |-> (intpnd_vec[id_m1] && ((intpnd_vec & below) == '0)));
  // R2
  idle_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_id == 16'd0) |-> (intpnd_vec == '0 && !stat_pend));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl[1]);
  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> !txrqst_vec[$past(tx_obj)]);
  // R3
  store_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fire |=> (newdat_vec[$past(rx_idx)] && intpnd_vec[$past(rx_idx)]));
  // R4
  lost_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rx_lost) |=> msglst_vec[$past(rx_idx)]);
  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !stat_set) |=> !stat_pend);
  // R7
  lec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_evt |=> status[2:0] == $past(bus_lec));
endmodule

bind msg_obj_irq_unit msgu_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .irq(irq), .int_id(int_id),
  .intpnd_vec(intpnd_vec), .newdat_vec(newdat_vec), .msglst_vec(msglst_vec),
  .txrqst_vec(txrqst_vec), .status(status), .stat_pend(stat_pend),
  .stat_set(stat_set), .sts_rd(sts_rd), .bus_evt(bus_evt), .bus_lec(bus_lec),
  .tx_fire(tx_fire), .tx_obj(tx_obj), .rx_fire(rx_fire), .rx_lost(rx_lost),
  .rx_idx(rx_idx)
);

// File: tb/msg_obj_irq_unit_tb.sv
`timescale 1ns/1ps
module msg_obj_irq_unit_tb;
  localparam int N = 32, IW = 5, IDW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [3:0] ctrl = '0, cfg_bits = '0;
  logic cfg_we = 0, ack_we = 0, txreq_we = 0, rx_evt = 0, tx_done = 0;
  logic bus_evt = 0, rec_passive = 0, bus_off = 0, sts_we = 0, sts_rd = 0;
  logic [IW-1:0] obj_sel = '0, tx_obj = '0, rd_obj = '0;
  logic [2:0] ack_mask = '0, bus_lec = '0;
  logic [IDW-1:0] rx_id = '0;
  logic [7:0] tec = '0;
  logic [6:0] rec = '0;
  logic [4:0] sts_wdata = '0;
  logic [15:0] int_id, err_cnt;
  logic irq;
  logic [7:0] status;
  logic [N-1:0] intpnd_vec, newdat_vec, msglst_vec, txrqst_vec;
  logic [IDW-1:0] rd_id;

  msg_obj_irq_unit #(.N(N), .IDW(IDW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;

  // reference state
  bit [N-1:0] m_valid, m_tx, m_eob, m_txie, m_intpnd, m_newdat, m_msglst, m_txrqst;
  logic [IDW-1:0] m_id [N];
  bit m_boff, m_warn, m_pass, m_rxok, m_txok, m_pend;
  bit [2:0] m_lec = 3'd7;
  bit [15:0] m_err;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_id();
    if (m_pend) return 16'h8000;
    for (int i = 0; i < N; i++) if (m_intpnd[i]) return 16'(i + 1);
    return 16'd0;
  endfunction

  task automatic model_update();
    int endi, tgt;
    bit lost, rxf, txf, nb, nw, np, chg, setp;
    endi = -1; tgt = -1; lost = 0;
    for (int i = 0; i < N; i++)
      if (endi < 0 && m_valid[i] && !m_tx[i] && m_eob[i]) endi = i;
    if (endi < 0)
      for (int i = 0; i < N; i++) if (m_valid[i] && !m_tx[i]) endi = i;
    if (endi >= 0) begin
      for (int i = endi; i >= 0; i--)
        if (m_valid[i] && !m_tx[i] && !m_newdat[i]) tgt = i;
      if (tgt < 0) begin tgt = endi; lost = 1; end
    end
    rxf = rx_evt && (tgt >= 0);
    txf = tx_done && m_txrqst[tx_obj];
    nb = bus_off;
    nw = (tec >= 8'd96) || (rec >= 7'd96);
    np = (tec >= 8'd128) || rec_passive;
    chg = (nb != m_boff) || (nw != m_warn) || (np != m_pass);
    setp = (chg && ctrl[3]) || ((rxf || txf) && ctrl[2]);
    m_boff = nb; m_warn = nw; m_pass = np;
    m_err = {rec_passive, rec, tec};
    if (sts_we) begin m_rxok = sts_wdata[4]; m_txok = sts_wdata[3]; m_lec = sts_wdata[2:0]; end
    if (rxf) m_rxok = 1;
    if (txf) m_txok = 1;
    if (bus_evt) m_lec = bus_lec;
    if (sts_rd) m_pend = 0;
    if (setp) m_pend = 1;
    if (cfg_we) begin
      m_valid[obj_sel] = cfg_bits[0]; m_tx[obj_sel] = cfg_bits[1];
      m_eob[obj_sel] = cfg_bits[2]; m_txie[obj_sel] = cfg_bits[3];
      m_newdat[obj_sel] = 0; m_intpnd[obj_sel] = 0; m_msglst[obj_sel] = 0; m_txrqst[obj_sel] = 0;
    end
    if (ack_we) begin
      if (ack_mask[0]) m_newdat[obj_sel] = 0;
      if (ack_mask[1]) m_intpnd[obj_sel] = 0;
      if (ack_mask[2]) m_msglst[obj_sel] = 0;
    end
    if (txreq_we) m_txrqst[obj_sel] = 1;
    if (txf) begin
      m_txrqst[tx_obj] = 0;
      if (m_txie[tx_obj]) m_intpnd[tx_obj] = 1;
    end
    if (rxf) begin
      m_newdat[tgt] = 1; m_intpnd[tgt] = 1; m_id[tgt] = rx_id;
      if (lost) m_msglst[tgt] = 1;
    end
  endtask

  task automatic compare_all();
    chk("R2 int_id", int_id, exp_id());
    chk("R9 irq", irq, ctrl[1] && (exp_id() != 0));
    chk("R6 status[7:3]", status[7:3], {m_boff, m_warn, m_pass, m_rxok, m_txok});
    chk("R7 status lec", status[2:0], m_lec);
    chk("R6 err_cnt", err_cnt, m_err);
    chk("R3 newdat_vec", newdat_vec, m_newdat);
    chk("R3 intpnd_vec", intpnd_vec, m_intpnd);
    chk("R4 msglst_vec", msglst_vec, m_msglst);
    chk("R5 txrqst_vec", txrqst_vec, m_txrqst);
    chk("R11 rd_id", rd_id, m_id[rd_obj]);
  endtask

  task automatic clear_pulses();
    cfg_we = 0; ack_we = 0; txreq_we = 0; rx_evt = 0; tx_done = 0;
    bus_evt = 0; sts_we = 0; sts_rd = 0;
  endtask

  task automatic step();
    model_update();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    clear_pulses();
  endtask

  task automatic do_rx(input logic [IDW-1:0] id);
    rx_evt = 1; rx_id = id; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_id[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 int_id", int_id, 16'd0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 status", status, 8'h07);
    chk("R1 err_cnt", err_cnt, 16'd0);
    chk("R1 flags", {intpnd_vec, newdat_vec, msglst_vec, txrqst_vec}, '0);
    rst_n = 1;
    ctrl = 4'b1110;
    step();
    chk("R1 after release", {int_id, status}, {16'd0, 8'h07});

    // configure: 0..15 receive chain ending at 15, 16..31 transmit
    for (int i = 0; i < N; i++) begin
      cfg_we = 1; obj_sel = IW'(i);
      cfg_bits = (i < 16) ? {1'b0, (i == 15), 1'b0, 1'b1} : {(i % 2 == 0), 1'b0, 1'b1, 1'b1};
      step();
    end

    do_rx(11'h123);
    chk("R3 first store obj0", newdat_vec, 32'h1);
    chk("R8 status interrupt code", int_id, 16'h8000);
    sts_rd = 1; rd_obj = 0; step();
    chk("R8 cleared by read", int_id, 16'd1);
    chk("R11 stored id", rd_id, 11'h123);
    do_rx(11'h045);
    ack_we = 1; obj_sel = 0; ack_mask = 3'b001; step();
    chk("R10 ack clears newdat only", {newdat_vec[1:0], intpnd_vec[0]}, 3'b101);
    do_rx(11'h066);
    chk("R3 refill lowest free", newdat_vec, 32'h3);
    for (int i = 2; i < 16; i++) do_rx(IDW'(i));
    chk("R3 chain full", newdat_vec, 32'h0000_FFFF);
    chk("R4 no loss yet", msglst_vec, 32'h0);
    rd_obj = 15;
    do_rx(11'h7FF);
    chk("R4 end object lost", msglst_vec, 32'h0000_8000);
    chk("R4 overwritten id", rd_id, 11'h7FF);
    chk("R4 stays in rx range", newdat_vec[31:16], 16'h0);

    sts_rd = 1; step();
    txreq_we = 1; obj_sel = 16; step();
    chk("R10 request set", txrqst_vec[16], 1'b1);
    tx_done = 1; tx_obj = 16; step();
    chk("R5 request cleared", txrqst_vec[16], 1'b0);
    chk("R5 pending set", intpnd_vec[16], 1'b1);
    chk("R5 tx ok", status[3], 1'b1);
    sts_we = 1; sts_wdata = 5'b00000; sts_rd = 1; step();
    tx_done = 1; tx_obj = 17; step();
    chk("R5 no request no effect", {status[3], intpnd_vec[17], int_id}, {1'b0, 1'b0, 16'd1});

    ctrl = 4'b0110; tec = 8'd100; step();
    chk("R6 warning", status[7:5], 3'b010);
    chk("R8 change masked", int_id, 16'd1);
    ctrl = 4'b1110; tec = 8'd130; step();
    chk("R6 passive", status[7:5], 3'b011);
    chk("R8 change raises", int_id, 16'h8000);
    ctrl = 4'b1100; step();
    chk("R9 line gated", irq, 1'b0);
    ctrl = 4'b1110; sts_rd = 1; step();
    chk("R9 line up", irq, 1'b1);

    sts_we = 1; sts_wdata = 5'b00111; bus_evt = 1; bus_lec = 3'd3; step();
    chk("R7 bus event wins", status[2:0], 3'd3);
    sts_we = 1; sts_wdata = 5'b00111; step();
    chk("R7 software marker", status[2:0], 3'd7);
    bus_evt = 1; bus_lec = 3'd6; step();
    chk("R7 new code", status[2:0], 3'd6);

    // random phase
    for (int c = 0; c < 6000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      rd_obj = IW'($urandom);
      obj_sel = IW'($urandom);
      if (r < 3) begin cfg_we = 1; cfg_bits = 4'($urandom); end
      else if (r < 30) begin ack_we = 1; ack_mask = 3'($urandom); end
      else if (r < 45) txreq_we = 1;
      if ($urandom_range(0, 99) < 35) begin rx_evt = 1; rx_id = IDW'($urandom); end
      if ($urandom_range(0, 99) < 25) begin tx_done = 1; tx_obj = IW'($urandom); end
      if ($urandom_range(0, 99) < 10) begin bus_evt = 1; bus_lec = 3'($urandom); end
      if ($urandom_range(0, 99) < 5) begin sts_we = 1; sts_wdata = 5'($urandom); end
      if ($urandom_range(0, 99) < 15) sts_rd = 1;
      if ($urandom_range(0, 99) < 4) begin
        tec = 8'($urandom); rec = 7'($urandom);
        rec_passive = 1'($urandom); bus_off = 1'($urandom);
      end
      if ($urandom_range(0, 99) < 2) ctrl = 4'($urandom);
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule